// File: doc/BRIEF.md
# Programmable RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB display panel. A programmable divider turns the system clock into a pixel-rate enable. A pixel counter walks each line and a line counter walks each frame. From their positions the block decodes horizontal sync, vertical sync and a data-enable strobe, and it reports the position of the current pixel inside the visible area. The downstream pixel path uses this position to fetch and format its data.

Each line has four regions in this order: sync pulse, back porch, active pixels and front porch. Each frame has the same four regions counted in lines. All region lengths are programmed as length minus one. The divide value, the region lengths and the three polarity selects are copied into shadow registers only while the block is idle or on the final pixel of a frame. A frame therefore always runs with one consistent set of values.

A timing-enable input starts the raster at the top-left corner, where both syncs are asserted. When the input is dropped, the current frame runs to its end and the block then goes quiet.

Top module: `rgb_timing_gen`

## Requirements
- R1: `pix_ce` pulses for one clock once every `div_val`+1 clocks. A `div_val` of 0 gives the same period as 1, that is one pulse every 2 clocks. `div_val` is 6 bits wide, so 63 gives one pulse every 64 clocks.
- R2: A line lasts (h_sync_m1+1)+(h_back_m1+1)+(h_active_m1+1)+(h_front_m1+1) pixels. Horizontal sync is active during the first h_sync_m1+1 pixels of every line.
- R3: A frame lasts the sum of the four vertical region lengths, each of them plus one, in lines. Vertical sync is active for the whole of the first v_sync_m1+1 lines of every frame.
- R4: The data-enable is active only when the pixel lies in the active horizontal region and the line lies in the active vertical region. It covers h_active_m1+1 pixels on each of v_active_m1+1 lines.
- R5: While the data-enable is active, `pix_x` and `pix_y` give the pixel's offset from the first active pixel and the first active line. At all other times both are 0.
- R6: A polarity select of 1 makes the matching output (`hsync`, `vsync` or `de`) high when active. A select of 0 makes it low when active. While the block is idle, each output sits at its inactive level.
- R7: When `tg_en` is high while the block is idle, the next pixel enable belongs to pixel 0 of line 0, and at that pixel both syncs are active.
- R8: When `tg_en` drops, the frame in progress completes. After its last pixel, `pix_ce` stays low, all three outputs are inactive and both coordinates are 0.
- R9: Inputs that change during a running frame do not affect that frame. They apply from the first pixel of the next frame, and this includes `div_val`.
- R10: During and after reset the block is idle: `pix_ce` is low, and `hsync`, `vsync` and `de` are high, because all three are active low by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tg_en | input | 1 | Timing enable: start raster / stop after the current frame |
| div_val | input | 6 | Pixel divide value; pixel rate = clk/(div_val+1), 0 treated as 1 |
| h_active_m1 | input | 12 | Active pixels per line minus one |
| h_sync_m1 | input | 8 | Horizontal sync width minus one |
| h_back_m1 | input | 8 | Horizontal back porch minus one |
| h_front_m1 | input | 8 | Horizontal front porch minus one |
| v_active_m1 | input | 12 | Active lines per frame minus one |
| v_sync_m1 | input | 8 | Vertical sync width in lines minus one |
| v_back_m1 | input | 8 | Vertical back porch minus one |
| v_front_m1 | input | 8 | Vertical front porch minus one |
| hs_pol_hi | input | 1 | 1: horizontal sync active high |
| vs_pol_hi | input | 1 | 1: vertical sync active high |
| de_pol_hi | input | 1 | 1: data enable active high |
| pix_ce | output | 1 | One-clock pixel enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | 12 | Active-area pixel column |
| pix_y | output | 12 | Active-area line row |

## Verification
A divider count that is off by one shows up as a wrong spacing between `pix_ce` pulses from the second pulse onward. A pixel or line counter that wraps at the wrong position shifts the sync and data-enable windows. The shift appears within the first line, or within the first frame for the line counter. A shadow register that loads in the middle of a frame changes the line length or the polarity before the frame ends, so the frame that spans the input change exposes it pixel by pixel. A stop handled too early or too late shows up as missing or extra `pix_ce` pulses after the last pixel of the frame.

// File: rtl/rgb_tg_pkg.sv
package rgb_tg_pkg;

    localparam int ACT_W   = 12;
    localparam int PORCH_W = 8;
    localparam int DIV_W   = 6;
    localparam int CNT_W   = ACT_W + 2;

    typedef struct packed {
        logic [ACT_W-1:0]   act_m1;
        logic [PORCH_W-1:0] sw_m1;
        logic [PORCH_W-1:0] bp_m1;
        logic [PORCH_W-1:0] fp_m1;
    } axis_cfg_t;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        axis_cfg_t        h;
        axis_cfg_t        v;
        logic             pol_hs;
        logic             pol_vs;
        logic             pol_de;
    } tg_cfg_t;

    function automatic logic drive_pol(input logic active, input logic act_high);
        return act_high ? active : ~active;
    endfunction

endpackage

// File: rtl/rgb_pix_div.sv
module rgb_pix_div #(
    parameter int DW = rgb_tg_pkg::DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          ce
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] cnt;
    logic [DW-1:0] lim;

    assign lim = (div == '0) ? ONE : div;
    assign ce  = run && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run || ce)
            cnt <= '0;
        else
            cnt <= cnt + ONE;
    end

    // the effective divide value is at least 1, so two enables never touch
    assert_ce_gap_R1: assert property (@(posedge clk) disable iff (rst)
        ce |=> !ce)
        else $error("pixel enable on consecutive clocks");

endmodule

// File: rtl/rgb_axis_ctr.sv
module rgb_axis_ctr #(
    parameter int AW = rgb_tg_pkg::ACT_W,
    parameter int PW = rgb_tg_pkg::PORCH_W,
    parameter int CW = rgb_tg_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic [AW-1:0] act_m1,
    input  logic [PW-1:0] sw_m1,
    input  logic [PW-1:0] bp_m1,
    input  logic [PW-1:0] fp_m1,
    output logic          last,
    output logic          in_sync,
    output logic          in_act,
    output logic [AW-1:0] coord
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] sync_end, act_start, act_end, last_idx;

    assign sync_end  = CW'(sw_m1) + ONE;
    assign act_start = sync_end + CW'(bp_m1) + ONE;
    assign act_end   = act_start + CW'(act_m1) + ONE;
    assign last_idx  = act_end + CW'(fp_m1);

    assign in_sync = cnt < sync_end;
    assign in_act  = (cnt >= act_start) && (cnt < act_end);
    assign last    = cnt == last_idx;
    assign coord   = in_act ? AW'(cnt - act_start) : '0;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (step)
            cnt <= last ? '0 : cnt + ONE;
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_idx)
        else $error("position counter beyond programmed total");

endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen
    import rgb_tg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tg_en,
    input  logic [DIV_W-1:0]   div_val,
    input  logic [ACT_W-1:0]   h_active_m1,
    input  logic [PORCH_W-1:0] h_sync_m1,
    input  logic [PORCH_W-1:0] h_back_m1,
    input  logic [PORCH_W-1:0] h_front_m1,
    input  logic [ACT_W-1:0]   v_active_m1,
    input  logic [PORCH_W-1:0] v_sync_m1,
    input  logic [PORCH_W-1:0] v_back_m1,
    input  logic [PORCH_W-1:0] v_front_m1,
    input  logic               hs_pol_hi,
    input  logic               vs_pol_hi,
    input  logic               de_pol_hi,
    output logic               pix_ce,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [ACT_W-1:0]   pix_x,
    output logic [ACT_W-1:0]   pix_y
);
    tg_cfg_t live, sh;
    logic    run;
    logic    h_last, h_sync, h_act;
    logic    v_last, v_sync, v_act;
    logic [ACT_W-1:0] hx, vy;
    logic    frame_last;
    logic    hs_act, vs_act, de_act;

    assign live = '{div: div_val,
                    h: '{act_m1: h_active_m1, sw_m1: h_sync_m1,
                         bp_m1: h_back_m1, fp_m1: h_front_m1},
                    v: '{act_m1: v_active_m1, sw_m1: v_sync_m1,
                         bp_m1: v_back_m1, fp_m1: v_front_m1},
                    pol_hs: hs_pol_hi, pol_vs: vs_pol_hi, pol_de: de_pol_hi};

    rgb_pix_div #(.DW(DIV_W)) u_div (
        .clk(clk), .rst(rst), .run(run), .div(sh.div), .ce(pix_ce)
    );

    rgb_axis_ctr #(.AW(ACT_W), .PW(PORCH_W), .CW(CNT_W)) u_hctr (
        .clk(clk), .rst(rst), .clr(!run), .step(pix_ce),
        .act_m1(sh.h.act_m1), .sw_m1(sh.h.sw_m1),
        .bp_m1(sh.h.bp_m1), .fp_m1(sh.h.fp_m1),
        .last(h_last), .in_sync(h_sync), .in_act(h_act), .coord(hx)
    );

    rgb_axis_ctr #(.AW(ACT_W), .PW(PORCH_W), .CW(CNT_W)) u_vctr (
        .clk(clk), .rst(rst), .clr(!run), .step(pix_ce && h_last),
        .act_m1(sh.v.act_m1), .sw_m1(sh.v.sw_m1),
        .bp_m1(sh.v.bp_m1), .fp_m1(sh.v.fp_m1),
        .last(v_last), .in_sync(v_sync), .in_act(v_act), .coord(vy)
    );

    assign frame_last = pix_ce && h_last && v_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            sh  <= '0;
        end else begin
            if (!run || frame_last)
                sh <= live;
            if (!run)
                run <= tg_en;
            else if (frame_last && !tg_en)
                run <= 1'b0;
        end
    end

    assign hs_act = run && h_sync;
    assign vs_act = run && v_sync;
    assign de_act = run && h_act && v_act;

    assign hsync = drive_pol(hs_act, sh.pol_hs);
    assign vsync = drive_pol(vs_act, sh.pol_vs);
    assign de    = drive_pol(de_act, sh.pol_de);
    assign pix_x = de_act ? hx : '0;
    assign pix_y = de_act ? vy : '0;

    assert_de_no_sync_R4: assert property (@(posedge clk) disable iff (rst)
        de_act |-> !hs_act && !vs_act)
        else $error("data enable overlaps a sync pulse");

    assert_origin_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> h_sync && v_sync)
        else $error("raster did not start at the origin");

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !run |-> !pix_ce)
        else $error("pixel enable while idle");

    assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
        run && frame_last && !tg_en |=> !run)
        else $error("raster kept running after stop request");

    assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) && !$past(frame_last) |-> $stable(sh))
        else $error("shadow timing changed inside a frame");

endmodule

// File: tb/rgb_timing_gen_test.sv
module rgb_timing_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tg_en = 1'b0;
    logic [5:0]  div_val = '0;
    logic [11:0] h_active_m1 = '0, v_active_m1 = '0;
    logic [7:0]  h_sync_m1 = '0, h_back_m1 = '0, h_front_m1 = '0;
    logic [7:0]  v_sync_m1 = '0, v_back_m1 = '0, v_front_m1 = '0;
    logic        hs_pol_hi = 1'b0, vs_pol_hi = 1'b0, de_pol_hi = 1'b0;
    logic        pix_ce, hsync, vsync, de;
    logic [11:0] pix_x, pix_y;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    rgb_timing_gen uut (
        .clk(clk), .rst(rst), .tg_en(tg_en), .div_val(div_val),
        .h_active_m1(h_active_m1), .h_sync_m1(h_sync_m1),
        .h_back_m1(h_back_m1), .h_front_m1(h_front_m1),
        .v_active_m1(v_active_m1), .v_sync_m1(v_sync_m1),
        .v_back_m1(v_back_m1), .v_front_m1(v_front_m1),
        .hs_pol_hi(hs_pol_hi), .vs_pol_hi(vs_pol_hi), .de_pol_hi(de_pol_hi),
        .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y)
    );

    typedef struct {
        int div;
        int hs, hb, ha, hf;
        int vs, vb, va, vf;
        bit phs, pvs, pde;
    } cfg_t;

    // divide value, expected clocks between pixel enables
    localparam int DIV_TAB[5][2] = '{'{0, 2}, '{1, 2}, '{2, 3}, '{5, 6}, '{63, 64}};

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic apply(input cfg_t c);
        div_val     = 6'(c.div);
        h_sync_m1   = 8'(c.hs - 1);
        h_back_m1   = 8'(c.hb - 1);
        h_active_m1 = 12'(c.ha - 1);
        h_front_m1  = 8'(c.hf - 1);
        v_sync_m1   = 8'(c.vs - 1);
        v_back_m1   = 8'(c.vb - 1);
        v_active_m1 = 12'(c.va - 1);
        v_front_m1  = 8'(c.vf - 1);
        hs_pol_hi   = c.phs;
        vs_pol_hi   = c.pvs;
        de_pol_hi   = c.pde;
    endtask

    task automatic wait_ce(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (pix_ce) break;
        end
    endtask

    task automatic walk_frame(input cfg_t c, input bit gap_first, input bit first_frame,
                              input bit chg, input cfg_t nc, input bit drop_en);
        int htot, vtot, eff, n;
        htot = c.hs + c.hb + c.ha + c.hf;
        vtot = c.vs + c.vb + c.va + c.vf;
        eff  = (c.div == 0) ? 1 : c.div;
        for (int i = 0; i < htot * vtot; i++) begin
            int h, v;
            bit hs_a, vs_a, de_a;
            wait_ce(n);
            h = i % htot;
            v = i / htot;
            hs_a = h < c.hs;
            vs_a = v < c.vs;
            de_a = (h >= c.hs + c.hb) && (h < c.hs + c.hb + c.ha) &&
                   (v >= c.vs + c.vb) && (v < c.vs + c.vb + c.va);
            if (i > 0 || gap_first) chk("R1 R9 pixel period", n, eff + 1);
            if (i == 0 && first_frame) begin
                chk("R7 first pixel hsync active", int'(hsync), int'(c.phs));
                chk("R7 first pixel vsync active", int'(vsync), int'(c.pvs));
            end
            chk("R2 R6 R9 hsync", int'(hsync), int'(c.phs ? hs_a : !hs_a));
            chk("R3 R6 vsync", int'(vsync), int'(c.pvs ? vs_a : !vs_a));
            chk("R4 R6 de", int'(de), int'(c.pde ? de_a : !de_a));
            chk("R5 pix_x", int'(pix_x), de_a ? h - c.hs - c.hb : 0);
            chk("R5 pix_y", int'(pix_y), de_a ? v - c.vs - c.vb : 0);
            if (i == 0 && chg) apply(nc);
            if (i == 0 && drop_en) tg_en = 1'b0;
        end
    endtask

    initial begin
        #(4 * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cfg_t a, b;
        int n;
        a = '{div: 1, hs: 1, hb: 1, ha: 4, hf: 1, vs: 1, vb: 1, va: 3, vf: 1,
              phs: 1'b0, pvs: 1'b0, pde: 1'b0};
        b = '{div: 2, hs: 2, hb: 1, ha: 5, hf: 2, vs: 2, vb: 1, va: 2, vf: 1,
              phs: 1'b1, pvs: 1'b1, pde: 1'b1};

        // reset state (R10)
        apply(a);
        repeat (3) @(negedge clk);
        chk("R10 pix_ce in reset", int'(pix_ce), 0);
        chk("R10 hsync in reset", int'(hsync), 1);
        chk("R10 vsync in reset", int'(vsync), 1);
        chk("R10 de in reset", int'(de), 1);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R10 idle pix_ce after reset", int'(pix_ce), 0);
            chk("R10 idle de after reset", int'(de), 1);
        end

        // divider vector table (R1)
        for (int t = 0; t < 5; t++) begin
            rst = 1'b1;
            tg_en = 1'b1;
            div_val = 6'(DIV_TAB[t][0]);
            repeat (2) @(negedge clk);
            rst = 1'b0;
            wait_ce(n);
            wait_ce(n);
            wait_ce(n);
            chk($sformatf("R1 period for divide %0d", DIV_TAB[t][0]), n, DIV_TAB[t][1]);
        end

        // full raster: start, mid-frame change, stop
        rst = 1'b1;
        tg_en = 1'b0;
        apply(a);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        tg_en = 1'b1;
        walk_frame(a, 1'b0, 1'b1, 1'b0, a, 1'b0);
        walk_frame(a, 1'b1, 1'b0, 1'b1, b, 1'b0);  // R9: change lands at next frame
        walk_frame(b, 1'b1, 1'b0, 1'b0, b, 1'b1);  // R8: stop requested mid-frame
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R8 no pix_ce after stop", int'(pix_ce), 0);
            chk("R8 R6 hsync inactive", int'(hsync), 0);
            chk("R8 R6 vsync inactive", int'(vsync), 0);
            chk("R8 R6 de inactive", int'(de), 0);
            chk("R8 pix_x zero", int'(pix_x), 0);
            chk("R8 pix_y zero", int'(pix_y), 0);
        end

        finish_run();
    end

endmodule